// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses an SDRAM-style memory walks through during a burst. A mode load sets the burst length, the wrap order and the CAS latency. Each later column command supplies a start column, a bank and a read/write flag. The block then presents one column address per clock until the burst is done. A new command on any clock cuts the running burst short and starts again from the new column.

For reads, a data-valid strobe follows every issued beat after the programmed CAS latency. The memory-side logic can use it to capture returning data. Write bursts step through addresses in the same way but never raise the strobe.

Timing convention: a command sampled at rising edge N gives beat 0 on the outputs right after edge N, and beat k right after edge N+k.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beat_valid, last_beat and rd_valid are low. The mode is burst length 1, sequential order and CAS latency 2.
- R2: The burst length code mode_bl selects 000=1, 001=2, 010=4 or 011=8 beats. A burst holds beat_valid high for exactly that many consecutive cycles, starting right after the command edge. last_beat is high only on the final beat, and beat_valid drops after it unless a new command arrives.
- R3: When mode_wrap=0 (sequential), beat k has its low log2(BL) bits equal to (start + k) mod BL.
- R4: When mode_wrap=1 (interleave), beat k has its low log2(BL) bits equal to the start's low bits XOR k.
- R5: Column bits above the low log2(BL) bits, and the bank, stay equal to the command's values for the whole burst.
- R6: A command accepted while a burst is running ends that burst. Beat 0 of the new burst appears after that same edge.
- R7: The CAS latency code mode_cl selects 010=2 or 011=3. rd_valid is high in the cycle CL clocks after each read beat is issued.
- R8: Write bursts (cmd_write=1) never raise rd_valid.
- R9: A mode load with mode_bl[2]=1 keeps the previous burst length. A mode load whose mode_cl is neither 010 nor 011 keeps the previous CAS latency.
- R10: Burst length and wrap order are captured when a command is accepted. A mode load during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load mode fields this cycle |
| mode_bl | input | 3 | Burst length code |
| mode_wrap | input | 1 | 0 sequential, 1 interleave |
| mode_cl | input | 3 | CAS latency code |
| cmd_valid | input | 1 | Column command present |
| cmd_write | input | 1 | 1 for write burst, 0 for read |
| cmd_col | input | COL_W | Start column |
| cmd_bank | input | BANK_W | Bank of the burst |
| col_addr | output | COL_W | Current beat column |
| bank | output | BANK_W | Current beat bank |
| beat_valid | output | 1 | A beat is issued this cycle |
| last_beat | output | 1 | Final beat of the burst |
| rd_valid | output | 1 | Read data valid, delayed by CL |

## Verification
The bench sweeps every start offset inside an 8-column block, for all four lengths and both orders. A design that wrapped outside the aligned block, or that applied XOR to the upper bits, would show wrong columns or a changing bank. Preemption mid-burst catches a design that finishes the old burst first. CL 2 and 3 read bursts, plus a write burst, catch a strobe tapped at the wrong depth or one raised on writes. Illegal mode codes, and a mode load in the middle of a burst, catch a design that corrupts or re-reads its settings.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [2:0]        mode_bl,
  input  logic              mode_wrap,
  input  logic [2:0]        mode_cl,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic [BANK_W-1:0] bank,
  output logic              beat_valid,
  output logic              last_beat,
  output logic              rd_valid
);
  localparam int IDX_W = 3;
  localparam int SR_W  = 3;

  logic [1:0]        m_len;
  logic              m_wrap;
  logic              m_cl3;

  logic [COL_W-1:0]  b_start;
  logic [BANK_W-1:0] b_bank;
  logic [1:0]        b_len;
  logic              b_wrap;
  logic              b_write;
  logic              b_active;
  logic [IDX_W-1:0]  b_idx;
  logic [SR_W-1:0]   rd_sr;

  logic [COL_W-1:0]  mask;
  logic [IDX_W-1:0]  last_idx;
  logic [COL_W-1:0]  idx_ext;
  logic [COL_W-1:0]  seq_col;
  logic [COL_W-1:0]  ilv_col;

  assign last_idx = IDX_W'((1 << b_len) - 1);
  assign mask     = COL_W'(last_idx);
  assign idx_ext  = COL_W'(b_idx);
  assign seq_col  = (b_start & ~mask) | ((b_start + idx_ext) & mask);
  assign ilv_col  = b_start ^ idx_ext;

  assign col_addr   = b_wrap ? ilv_col : seq_col;
  assign bank       = b_bank;
  assign beat_valid = b_active;
  assign last_beat  = b_active && (b_idx == last_idx);
  assign rd_valid   = m_cl3 ? rd_sr[2] : rd_sr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_len  <= 2'd0;
      m_wrap <= 1'b0;
      m_cl3  <= 1'b0;
    end else if (mode_load) begin
      if (!mode_bl[2]) m_len <= mode_bl[1:0];
      m_wrap <= mode_wrap;
      if (mode_cl == 3'b010)      m_cl3 <= 1'b0;
      else if (mode_cl == 3'b011) m_cl3 <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_start  <= '0;
      b_bank   <= '0;
      b_len    <= 2'd0;
      b_wrap   <= 1'b0;
      b_write  <= 1'b0;
      b_active <= 1'b0;
      b_idx    <= '0;
    end else if (cmd_valid) begin
      b_start  <= cmd_col;
      b_bank   <= cmd_bank;
      b_len    <= m_len;
      b_wrap   <= m_wrap;
      b_write  <= cmd_write;
      b_active <= 1'b1;
      b_idx    <= '0;
    end else if (b_active) begin
      if (last_beat) b_active <= 1'b0;
      else           b_idx    <= b_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_sr <= '0;
    else        rd_sr <= {rd_sr[SR_W-2:0], b_active & ~b_write};
  end

  assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  assert_burst_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !cmd_valid) |=> !beat_valid);

  assert_bank_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !cmd_valid) |=> (beat_valid && $stable(bank)));

  assert_upper_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !cmd_valid) |=>
      ((col_addr & ~mask) == ($past(col_addr) & ~mask)));

  assert_cmd_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (beat_valid && bank == $past(cmd_bank)));
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [2:0] mode_bl = 3'b000;
  logic       mode_wrap = 1'b0;
  logic [2:0] mode_cl = 3'b010;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [1:0] cmd_bank = '0;
  logic [8:0] col_addr;
  logic [1:0] bank;
  logic       beat_valid, last_beat, rd_valid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  sdram_burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bl(mode_bl),
    .mode_wrap(mode_wrap), .mode_cl(mode_cl), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_bank(cmd_bank),
    .col_addr(col_addr), .bank(bank), .beat_valid(beat_valid),
    .last_beat(last_beat), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int k, int len, int wrap);
    int m = len - 1;
    if (wrap != 0) return s ^ k;
    return (s & ~m) | ((s + k) & m);
  endfunction

  task automatic load_mode(input logic [2:0] bl, input logic wr, input logic [2:0] cl);
    @(negedge clk);
    mode_load = 1'b1; mode_bl = bl; mode_wrap = wr; mode_cl = cl;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic issue(input int col, input int bk, input logic wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = 9'(col); cmd_bank = 2'(bk); cmd_write = wr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic burst(input string req, input int col, input int bk, input int len, input int wrap);
    issue(col, bk, 1'b1);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      chk(req, int'(col_addr), exp_col(col, k, len, wrap));
      chk("R5 bank", int'(bank), bk);
      chk("R2 valid", int'(beat_valid), 1);
      chk("R2 last", int'(last_beat), (k == len - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R2 end", int'(beat_valid), 0);
  endtask

  task automatic rd_window(input string req, input int len, input int cl, input logic wr);
    issue(9'h0A0, 1, wr);
    for (int j = 0; j < cl + len + 2; j++) begin
      if (j > 0) @(negedge clk);
      chk(req, int'(rd_valid), (!wr && j >= cl && j < cl + len) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 valid", int'(beat_valid), 0);
    chk("R1 last", int'(last_beat), 0);
    chk("R1 rd", int'(rd_valid), 0);
    burst("R1 default BL1", 9'h123, 2, 1, 0);
    rd_window("R1 default CL2", 1, 2, 1'b0);

    for (int wrap = 0; wrap < 2; wrap++) begin
      for (int blc = 0; blc < 4; blc++) begin
        load_mode(3'(blc), wrap[0], 3'b010);
        for (int s = 0; s < 8; s++)
          burst(wrap == 0 ? "R3 seq" : "R4 ilv", 9'h150 | s, s & 3, 1 << blc, wrap);
      end
    end

    load_mode(3'b011, 1'b0, 3'b010);
    issue(9'h105, 3, 1'b1);
    chk("R6 old b0", int'(col_addr), 9'h105);
    @(negedge clk);
    chk("R6 old b1", int'(col_addr), 9'h106);
    cmd_valid = 1'b1; cmd_col = 9'h0F3; cmd_bank = 2'd1; cmd_write = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 new col", int'(col_addr), 9'h0F3);
    chk("R6 new bank", int'(bank), 1);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk("R6 new seq", int'(col_addr), exp_col(9'h0F3, k, 8, 0));
    end
    @(negedge clk);
    chk("R6 end", int'(beat_valid), 0);

    load_mode(3'b001, 1'b0, 3'b010);
    rd_window("R7 CL2", 2, 2, 1'b0);
    load_mode(3'b010, 1'b0, 3'b011);
    rd_window("R7 CL3", 4, 3, 1'b0);
    rd_window("R8 write", 4, 3, 1'b1);

    load_mode(3'b100, 1'b1, 3'b001);
    burst("R9 BL kept", 9'h1C6, 0, 4, 1);
    rd_window("R9 CL kept", 4, 3, 1'b0);

    load_mode(3'b011, 1'b0, 3'b010);
    issue(9'h046, 2, 1'b1);
    mode_load = 1'b1; mode_bl = 3'b001; mode_wrap = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
    chk("R10 b1", int'(col_addr), exp_col(9'h046, 1, 8, 0));
    for (int k = 2; k < 8; k++) begin
      @(negedge clk);
      chk("R10 kept", int'(col_addr), exp_col(9'h046, k, 8, 0));
    end
    @(negedge clk);
    chk("R10 end", int'(beat_valid), 0);
    burst("R10 new mode", 9'h047, 0, 2, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule